// File: doc/BRIEF.md
# Flow Table with Per-Source Xoff Stall

This block holds a table of flow entries. Each entry pairs a destination ID with a selector that sets how many ID bits are compared. Flow-control messages arrive on a simple valid strobe. Each message carries a destination ID and an Xoff or Xon flag. The block resolves the message to one table entry and steps that entry's 8-bit Xoff count up or down. From the counts it drives a per-flow vector whose bit is high while the count is nonzero.

Each transmit source owns a mask that marks which flows it sends on. The block ANDs each mask with the per-flow vector and reports a stall line per source. The table and the masks are written and read through a flat register port. Writes take effect on the clock edge. Reads are combinational.

Top module: `flow_xoff_ctrl`

## Requirements
- R1: After reset, every entry reads selector 01 with ID 0x0000 (0x10000), every source mask reads 0xFFFF, and `xoff_vec` and `src_stall` are zero. Internal state leaves reset two clock edges after `rst_n` rises.
- R2: Address i (0 to 15) holds entry i. It reads as {selector[17:16], ID[15:0]}. Address 16+s holds the mask of source s in bits [15:0], and bits [17:16] read zero. Unmapped addresses read zero, and writes to them change nothing.
- R3: Selector 00 compares only bits [7:0] of the message ID and the entry ID. Selector 01 compares all 16 bits. Selectors 10 and 11 never match by comparison.
- R4: When several entries match, the lowest index wins. Entry 15 also matches any message that entries 0 to 14 all miss, but only while its stored ID is 0x0000.
- R5: An accepted Xoff adds one to the matched entry's count, and an Xon subtracts one. Bit i of `xoff_vec` is high while count i is nonzero. The new value shows after the edge that samples the message. A message that matches no entry changes nothing.
- R6: A count stops at 255 under further Xoffs and stays at 0 under further Xons.
- R7: Writing an entry clears its count on the same edge. The clear wins over a message that targets the same entry in that cycle.
- R8: A source stalls while any flow set in its mask has a nonzero count. A source whose mask is zero never stalls. A mask write takes effect after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 18 | Register write data |
| reg_rdata | output | 18 | Register read data (combinational) |
| fc_valid | input | 1 | Flow-control message strobe |
| fc_xoff | input | 1 | 1 = Xoff, 0 = Xon |
| fc_dest_id | input | 16 | Destination ID carried by the message |
| xoff_vec | output | 16 | Per-flow nonzero-count flags |
| src_stall | output | 4 | Per-source stall |

## Verification
The bench builds the block with its default parameters: 16 flows, 4 sources and 8-bit counts. With 8-bit counts, saturation at 255 can be reached in a few hundred messages, and a wrapping counter would show up as a wrong flag. Four sources let one run cover at the same time a zero mask, a single-flow mask, a wildcard-only mask and the all-ones reset mask.

// File: rtl/flow_xoff_pkg.sv
package flow_xoff_pkg;
  localparam int FC_ID_W = 16;

  typedef enum logic [1:0] {
    LEN_8    = 2'b00,
    LEN_16   = 2'b01,
    LEN_RSV2 = 2'b10,
    LEN_RSV3 = 2'b11
  } id_len_e;

  typedef struct packed {
    id_len_e              len;
    logic [FC_ID_W-1:0]   id;
  } flow_entry_t;

  localparam int ENTRY_W = $bits(flow_entry_t);
endpackage

// File: rtl/flow_match.sv
module flow_match
  import flow_xoff_pkg::*;
#(
  parameter int NUM_FLOWS = 16
) (
  input  flow_entry_t [NUM_FLOWS-1:0] tbl,
  input  logic [FC_ID_W-1:0]          rx_id,
  output logic [NUM_FLOWS-1:0]        grant
);
  localparam int LAST = NUM_FLOWS - 1;

  logic [NUM_FLOWS-1:0] hit;

  for (genvar i = 0; i < NUM_FLOWS; i++) begin : g_cmp
    always_comb begin
      unique case (tbl[i].len)
        LEN_8:   hit[i] = (tbl[i].id[7:0] == rx_id[7:0]);
        LEN_16:  hit[i] = (tbl[i].id == rx_id);
        default: hit[i] = 1'b0;
      endcase
    end
  end

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < LAST; i++) begin
      if (hit[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
    if (!found && (hit[LAST] || (tbl[LAST].id == '0))) begin
      grant[LAST] = 1'b1;
    end
  end
endmodule

// File: rtl/flow_cnt.sv
module flow_cnt #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  input  logic dec,
  output logic nz
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             cnt_en;

  assign cnt_en = clr | inc | dec;

  always_comb begin
    cnt_nxt = cnt_q;
    if (clr) begin
      cnt_nxt = '0;
    end else if (inc) begin
      if (cnt_q != CNT_MAX) cnt_nxt = cnt_q + 1'b1;
    end else if (dec) begin
      if (cnt_q != '0) cnt_nxt = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign nz = (cnt_q != '0);
endmodule

// File: rtl/flow_src_gate.sv
module flow_src_gate #(
  parameter int NUM_FLOWS = 16,
  parameter int NUM_SRC   = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_SRC-1:0]                  mask_we,
  input  logic [NUM_FLOWS-1:0]                mask_wdata,
  input  logic [NUM_FLOWS-1:0]                xoff_vec,
  output logic [NUM_SRC-1:0][NUM_FLOWS-1:0]   mask_q,
  output logic [NUM_SRC-1:0]                  stall
);
  logic [NUM_SRC-1:0][NUM_FLOWS-1:0] mask_nxt;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    always_comb begin
      mask_nxt[s] = mask_we[s] ? mask_wdata : mask_q[s];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[s] <= '1;
      end else if (mask_we[s]) begin
        mask_q[s] <= mask_nxt[s];
      end
    end

    assign stall[s] = |(mask_q[s] & xoff_vec);
  end
endmodule

// File: rtl/flow_xoff_ctrl.sv
module flow_xoff_ctrl
  import flow_xoff_pkg::*;
#(
  parameter  int NUM_FLOWS = 16,
  parameter  int NUM_SRC   = 4,
  parameter  int CNT_W     = 8,
  localparam int NUM_REGS  = NUM_FLOWS + NUM_SRC,
  localparam int ADDR_W    = $clog2(NUM_REGS),
  localparam int REG_DW    = ENTRY_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [REG_DW-1:0]    reg_wdata,
  output logic [REG_DW-1:0]    reg_rdata,
  input  logic                 fc_valid,
  input  logic                 fc_xoff,
  input  logic [FC_ID_W-1:0]   fc_dest_id,
  output logic [NUM_FLOWS-1:0] xoff_vec,
  output logic [NUM_SRC-1:0]   src_stall
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  // write decode
  logic [NUM_FLOWS-1:0] ent_we;
  logic [NUM_SRC-1:0]   mask_we;

  for (genvar i = 0; i < NUM_FLOWS; i++) begin : g_ent_dec
    assign ent_we[i] = reg_wr_en && (reg_addr == ADDR_W'(i));
  end
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_msk_dec
    assign mask_we[s] = reg_wr_en && (reg_addr == ADDR_W'(NUM_FLOWS + s));
  end

  // flow table
  flow_entry_t [NUM_FLOWS-1:0] tbl_q, tbl_nxt;

  always_comb begin
    for (int i = 0; i < NUM_FLOWS; i++) begin
      tbl_nxt[i] = ent_we[i] ? flow_entry_t'(reg_wdata) : tbl_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int i = 0; i < NUM_FLOWS; i++) begin
        tbl_q[i] <= '{len: LEN_16, id: '0};
      end
    end else if (|ent_we) begin
      tbl_q <= tbl_nxt;
    end
  end

  // message resolution
  logic [NUM_FLOWS-1:0] grant;

  flow_match #(.NUM_FLOWS(NUM_FLOWS)) u_match (
    .tbl   (tbl_q),
    .rx_id (fc_dest_id),
    .grant (grant)
  );

  // per-flow Xoff counters
  for (genvar i = 0; i < NUM_FLOWS; i++) begin : g_cnt
    flow_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .clr   (ent_we[i]),
      .inc   (fc_valid &  fc_xoff & grant[i]),
      .dec   (fc_valid & ~fc_xoff & grant[i]),
      .nz    (xoff_vec[i])
    );
  end

  // per-source masks and stall
  logic [NUM_SRC-1:0][NUM_FLOWS-1:0] src_mask;

  flow_src_gate #(.NUM_FLOWS(NUM_FLOWS), .NUM_SRC(NUM_SRC)) u_gate (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .mask_we    (mask_we),
    .mask_wdata (reg_wdata[NUM_FLOWS-1:0]),
    .xoff_vec   (xoff_vec),
    .mask_q     (src_mask),
    .stall      (src_stall)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_FLOWS; i++) begin
      if (reg_addr == ADDR_W'(i)) reg_rdata = tbl_q[i];
    end
    for (int s = 0; s < NUM_SRC; s++) begin
      if (reg_addr == ADDR_W'(NUM_FLOWS + s)) reg_rdata = REG_DW'(src_mask[s]);
    end
  end
endmodule

// File: rtl/flow_xoff_chk.sv
module flow_xoff_chk #(
  parameter int NUM_FLOWS = 16,
  parameter int NUM_SRC   = 4,
  parameter int ADDR_W    = 5
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               fc_valid,
  input logic                               fc_xoff,
  input logic                               reg_wr_en,
  input logic [ADDR_W-1:0]                  reg_addr,
  input logic [NUM_FLOWS-1:0]               grant,
  input logic [NUM_FLOWS-1:0]               xoff_vec,
  input logic [NUM_SRC-1:0]                 src_stall,
  input logic [NUM_SRC-1:0][NUM_FLOWS-1:0]  src_mask
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R4

  AST_ONLY_XOFF_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    !(fc_valid && fc_xoff) |=> ((xoff_vec & ~$past(xoff_vec)) == '0)); // R5

  AST_XOFF_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_valid && fc_xoff && !reg_wr_en) |=> ((xoff_vec & $past(grant)) == $past(grant))); // R5

  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && (reg_addr < ADDR_W'(NUM_FLOWS)))
      |=> ((xoff_vec & (NUM_FLOWS'(1) << $past(reg_addr))) == '0)); // R7

  AST_NO_FLOW_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (xoff_vec == '0) |-> (src_stall == '0)); // R8

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src_chk
    AST_ZERO_MASK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (src_mask[s] == '0) |-> !src_stall[s]); // R8
  end
endmodule

bind flow_xoff_ctrl flow_xoff_chk #(
  .NUM_FLOWS (NUM_FLOWS),
  .NUM_SRC   (NUM_SRC),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .fc_valid  (fc_valid),
  .fc_xoff   (fc_xoff),
  .reg_wr_en (reg_wr_en),
  .reg_addr  (reg_addr),
  .grant     (grant),
  .xoff_vec  (xoff_vec),
  .src_stall (src_stall),
  .src_mask  (src_mask)
);

// File: tb/tb_flow_xoff_ctrl.sv
module tb_flow_xoff_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [4:0]  reg_addr;
  logic [17:0] reg_wdata;
  logic [17:0] reg_rdata;
  logic        fc_valid;
  logic        fc_xoff;
  logic [15:0] fc_dest_id;
  logic [15:0] xoff_vec;
  logic [3:0]  src_stall;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  flow_xoff_ctrl dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .fc_valid   (fc_valid),
    .fc_xoff    (fc_xoff),
    .fc_dest_id (fc_dest_id),
    .xoff_vec   (xoff_vec),
    .src_stall  (src_stall)
  );

  // op: 0 = register write, 1 = Xoff, 2 = Xon
  // fields: op[69:68] arg[67:52] data[51:20] exp_xoff[19:4] exp_stall[3:0]
  localparam int NV = 26;
  localparam logic [69:0] VEC [NV] = '{
    {2'd0, 16'd0,     32'h00011234, 16'h0000, 4'h0}, // R2 entry0 16-bit
    {2'd0, 16'd1,     32'h00000055, 16'h0000, 4'h0}, // R3 entry1 8-bit
    {2'd0, 16'd2,     32'h0001AB55, 16'h0000, 4'h0},
    {2'd0, 16'd3,     32'h00020077, 16'h0000, 4'h0}, // R3 reserved selector
    {2'd1, 16'h1234,  32'h0,        16'h0001, 4'hF}, // R5
    {2'd1, 16'h9955,  32'h0,        16'h0003, 4'hF}, // R3 low byte match
    {2'd1, 16'hAB55,  32'h0,        16'h0003, 4'hF}, // R4 entry1 beats entry2
    {2'd2, 16'hAB55,  32'h0,        16'h0003, 4'hF}, // R5 count 2 -> 1
    {2'd2, 16'h0055,  32'h0,        16'h0001, 4'hF}, // R5 count 1 -> 0
    {2'd1, 16'h0077,  32'h0,        16'h8001, 4'hF}, // R4 wildcard
    {2'd1, 16'h0000,  32'h0,        16'h8011, 4'hF}, // R4 entry4 beats wildcard
    {2'd2, 16'h0000,  32'h0,        16'h8001, 4'hF},
    {2'd0, 16'd16,    32'h00000002, 16'h8001, 4'hE}, // R8
    {2'd0, 16'd17,    32'h00000000, 16'h8001, 4'hC}, // R8 zero mask
    {2'd0, 16'd18,    32'h00008000, 16'h8001, 4'hC},
    {2'd0, 16'd19,    32'h00000100, 16'h8001, 4'h4},
    {2'd1, 16'h9955,  32'h0,        16'h8003, 4'h5}, // R8
    {2'd0, 16'd1,     32'h00000055, 16'h8001, 4'h4}, // R7 rewrite clears
    {2'd0, 16'd15,    32'h00010099, 16'h0001, 4'h0}, // R7 R4 wildcard off
    {2'd1, 16'h0077,  32'h0,        16'h0001, 4'h0}, // R5 unmatched ignored
    {2'd2, 16'h1234,  32'h0,        16'h0000, 4'h0},
    {2'd2, 16'h1234,  32'h0,        16'h0000, 4'h0}, // R6 floor
    {2'd1, 16'h1234,  32'h0,        16'h0001, 4'h0}, // R6 no underflow wrap
    {2'd0, 16'd20,    32'h0003BEEF, 16'h0001, 4'h0}, // R2 unmapped write
    {2'd0, 16'd8,     32'h00000042, 16'h0001, 4'h0},
    {2'd1, 16'h7742,  32'h0,        16'h0101, 4'h8}  // R8 single-flow mask
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [4:0] a, input logic [17:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic do_fc(input logic x, input logic [15:0] id);
    @(negedge clk);
    fc_valid = 1'b1; fc_xoff = x; fc_dest_id = id;
    @(negedge clk);
    fc_valid = 1'b0;
  endtask

  task automatic do_rd(input string req, input logic [4:0] a, input logic [17:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, 32'(reg_rdata), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    fc_valid = 1'b0; fc_xoff = 1'b0; fc_dest_id = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 xoff_vec", 32'(xoff_vec), 32'h0);
    check("R1 src_stall", 32'(src_stall), 32'h0);
    do_rd("R1 entry0", 5'd0, 18'h10000);
    do_rd("R1 entry15", 5'd15, 18'h10000);
    do_rd("R1 mask0", 5'd16, 18'h0FFFF);
    do_rd("R1 mask3", 5'd19, 18'h0FFFF);

    // vector table
    for (int k = 0; k < NV; k++) begin
      logic [69:0] v;
      v = VEC[k];
      case (v[69:68])
        2'd0:    do_wr(v[56:52], v[37:20]);
        2'd1:    do_fc(1'b1, v[67:52]);
        default: do_fc(1'b0, v[67:52]);
      endcase
      check($sformatf("R5 vec%0d xoff_vec", k), 32'(xoff_vec), 32'(v[19:4]));
      check($sformatf("R8 vec%0d src_stall", k), 32'(src_stall), 32'(v[3:0]));
    end

    // R2 readback
    do_rd("R2 entry0", 5'd0, 18'h11234);
    do_rd("R2 entry3 reserved sel", 5'd3, 18'h20077);
    do_rd("R2 entry5 default", 5'd5, 18'h10000);
    do_rd("R2 mask0", 5'd16, 18'h00002);
    do_rd("R2 unmapped", 5'd20, 18'h00000);
    do_rd("R2 unmapped 31", 5'd31, 18'h00000);
    do_wr(5'd9, 18'h3FFFF);
    do_rd("R2 entry9 all ones", 5'd9, 18'h3FFFF);
    do_wr(5'd18, 18'h3FFFF);
    do_rd("R2 mask upper bits zero", 5'd18, 18'h0FFFF);
    do_wr(5'd18, 18'h08000);

    // R6 saturation: 256 Xoffs then 254 Xons leaves count 1
    do_wr(5'd0, 18'h11234);
    check("R7 cleared by write", 32'(xoff_vec[0]), 32'h0);
    for (int k = 0; k < 256; k++) do_fc(1'b1, 16'h1234);
    check("R6 after 256 xoff", 32'(xoff_vec[0]), 32'h1);
    for (int k = 0; k < 254; k++) do_fc(1'b0, 16'h1234);
    check("R6 saturated at 255", 32'(xoff_vec[0]), 32'h1);
    do_fc(1'b0, 16'h1234);
    check("R6 reaches zero", 32'(xoff_vec[0]), 32'h0);

    // R7 write wins over a same-cycle Xoff to that entry
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 5'd0; reg_wdata = 18'h11234;
    fc_valid = 1'b1; fc_xoff = 1'b1; fc_dest_id = 16'h1234;
    @(negedge clk);
    reg_wr_en = 1'b0; fc_valid = 1'b0;
    check("R7 write beats xoff", 32'(xoff_vec[0]), 32'h0);

    // R3 reserved selector never matches by comparison (entry 9 = sel 11, id FFFF)
    do_fc(1'b1, 16'hFFFF);
    check("R3 reserved no match", 32'(xoff_vec), 32'h0100);

    // R1 asynchronous reset returns to the reset state
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async clear xoff_vec", 32'(xoff_vec), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_rd("R1 entry0 after reset", 5'd0, 18'h10000);
    do_rd("R1 mask1 after reset", 5'd17, 18'h0FFFF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule